// File: doc/BRIEF.md
# UART Receive Status and Error Handler

This block sits between a UART receive shifter and the host side of a serial port. Each received character arrives as a one-cycle strobe with its data word and three per-character error indications (framing, noise, parity). The block keeps the received character in a data register with a data-valid flag, and it keeps sticky framing, noise, parity and overrun flags. From this state it drives a DMA read request and an error interrupt.

Five configuration inputs select the behaviour. Overrun detection can be switched off, so that a new character silently replaces an unread one. A reception error can be handled in one of two ways: the erroneous character leaves data-valid low, or it raises data-valid and holds the DMA request off until the error flags are cleared. Single-sample mode turns noise reporting off. The host reads the data register with a read strobe, and it clears each error flag with its own clear strobe.

Top module: `uart_rx_status`

## Requirements
- R1: While reset is held and on the first cycle after reset, `rx_data` is 0 and `rx_valid`, all four flags, `dma_req` and `err_irq` are 0.
- R2: An accepted character is in `rx_data` on the cycle after its `char_stb`.
- R3: `rd_stb` clears `rx_valid` on the next cycle. When `rd_stb` and `char_stb` fall in the same cycle, the read is taken first: the character is accepted and no overrun is flagged.
- R4: With `cfg_ovr_off` = 0, a `char_stb` while `rx_valid` = 1 and `rd_stb` = 0 sets `flag_ore`. The character is dropped: `rx_data`, `rx_valid` and the other flags keep their values.
- R5: With `cfg_ovr_off` = 1, `flag_ore` is never set, and every character is written to `rx_data` even when `rx_valid` is 1.
- R6: An accepted character with an effective error (framing, parity, or noise when noise is counted) sets the matching flags. With `cfg_err_dma_mask` = 0 it leaves `rx_valid` at 0. A later good character gives `rx_valid` = 1.
- R7: With `cfg_err_dma_mask` = 1, an erroneous character sets its flags and `rx_valid`.
- R8: With `cfg_one_sample` = 1, `char_ne` is ignored: `flag_ne` is not set and the character does not count as erroneous.
- R9: Every flag stays set until its own clear strobe (`clr_fe`, `clr_ne`, `clr_pe`, `clr_ore`) is pulsed, and it clears on the next cycle. When a set and a clear fall in the same cycle, the flag is set.
- R10: `dma_req` = `cfg_dma_en` AND `rx_valid` AND NOT (`cfg_err_dma_mask` AND (`flag_fe` OR `flag_ne` OR `flag_pe`)).
- R11: `err_irq` = `cfg_err_ie` AND (`flag_fe` OR `flag_ore` OR `flag_ne`). A parity flag alone does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_stb | input | 1 | A received character is presented this cycle |
| char_data | input | DATA_W | Received character |
| char_fe | input | 1 | Framing error for this character |
| char_ne | input | 1 | Noise detected on this character |
| char_pe | input | 1 | Parity error for this character |
| rd_stb | input | 1 | Host reads the data register |
| clr_fe | input | 1 | Clear the framing flag |
| clr_ne | input | 1 | Clear the noise flag |
| clr_pe | input | 1 | Clear the parity flag |
| clr_ore | input | 1 | Clear the overrun flag |
| cfg_ovr_off | input | 1 | Turn overrun detection off |
| cfg_err_dma_mask | input | 1 | On error: 1 raises valid and masks DMA, 0 keeps valid low |
| cfg_dma_en | input | 1 | DMA receive enable |
| cfg_err_ie | input | 1 | Error interrupt enable |
| cfg_one_sample | input | 1 | Single-sample mode: noise is not reported |
| rx_data | output | DATA_W | Data register |
| rx_valid | output | 1 | Data-valid flag |
| flag_fe | output | 1 | Sticky framing error flag |
| flag_ne | output | 1 | Sticky noise flag |
| flag_pe | output | 1 | Sticky parity flag |
| flag_ore | output | 1 | Sticky overrun flag |
| dma_req | output | 1 | DMA read request |
| err_irq | output | 1 | Error interrupt |

## Verification
The assertions expect every input to have a known value from the first clock after reset. They allow strobes and configuration bits to change in any cycle, because the block samples them all with no handshake. The stimulus draws strobes and error bits afresh every cycle and changes the configuration only at window boundaries, so each mode is held long enough to reach overruns, masked requests and set-against-clear collisions. The random phase is followed by directed sequences that hit each corner on purpose.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int unsigned FLAG_N   = 4;
  localparam int unsigned FLAG_FE  = 0;
  localparam int unsigned FLAG_NE  = 1;
  localparam int unsigned FLAG_PE  = 2;
  localparam int unsigned FLAG_ORE = 3;

  typedef logic [FLAG_N-1:0] flag_vec_t;
endpackage

// File: rtl/rx_data_reg.sv
module rx_data_reg #(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_stb,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_err,
  input  logic              rd_stb,
  input  logic              cfg_ovr_off,
  input  logic              cfg_err_dma_mask,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              accept,
  output logic              overrun
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q, valid_d;

  // A read in the same cycle frees the register before the new character.
  assign overrun = char_stb & valid_q & ~rd_stb & ~cfg_ovr_off;
  assign accept  = char_stb & ~overrun;

  always_comb begin
    valid_d = valid_q;
    if (accept)      valid_d = ~char_err | cfg_err_dma_mask;
    else if (rd_stb) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (accept) data_q <= char_data;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;

  // R4: a dropped character leaves the register untouched
  a_r4_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (char_stb && rx_valid && !rd_stb && !cfg_ovr_off) |=> $stable(rx_data));
  // R5: with overrun off every character lands in the register
  a_r5_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (char_stb && cfg_ovr_off) |=> (rx_data == $past(char_data)));
  // R3: a lone read drops the valid flag
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !char_stb) |=> !rx_valid);
endmodule

// File: rtl/rx_err_flags.sv
module rx_err_flags
  import uart_rx_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  output flag_vec_t flags
);
  flag_vec_t flags_q;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    logic bit_d;
    always_comb bit_d = set_vec[g] | (flags_q[g] & ~clr_vec[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[g] <= 1'b0;
      else        flags_q[g] <= bit_d;
    end

    // R9: a set in the same cycle as a clear wins
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> flags_q[g]);
    // R9: without a set, a clear empties the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[g] && !set_vec[g]) |=> !flags_q[g]);
  end

  assign flags = flags_q;
endmodule

// File: rtl/rx_req_irq.sv
module rx_req_irq
  import uart_rx_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t flags,
  input  logic      rx_valid,
  input  logic      cfg_dma_en,
  input  logic      cfg_err_dma_mask,
  input  logic      cfg_err_ie,
  output logic      dma_req,
  output logic      err_irq
);
  logic rx_err_any;

  always_comb begin
    rx_err_any = flags[FLAG_FE] | flags[FLAG_NE] | flags[FLAG_PE];
    dma_req    = cfg_dma_en & rx_valid & ~(cfg_err_dma_mask & rx_err_any);
    err_irq    = cfg_err_ie & (flags[FLAG_FE] | flags[FLAG_ORE] | flags[FLAG_NE]);
  end

  // R10: a request always points at valid data
  a_r10_req_valid: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rx_valid);
  // R11: a parity flag alone never interrupts
  a_r11_pe_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == flag_vec_t'(1 << FLAG_PE)) |-> !err_irq);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int unsigned DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_stb,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_fe,
  input  logic              char_ne,
  input  logic              char_pe,
  input  logic              rd_stb,
  input  logic              clr_fe,
  input  logic              clr_ne,
  input  logic              clr_pe,
  input  logic              clr_ore,
  input  logic              cfg_ovr_off,
  input  logic              cfg_err_dma_mask,
  input  logic              cfg_dma_en,
  input  logic              cfg_err_ie,
  input  logic              cfg_one_sample,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              flag_fe,
  output logic              flag_ne,
  output logic              flag_pe,
  output logic              flag_ore,
  output logic              dma_req,
  output logic              err_irq
);
  logic      ne_eff, char_err, accept, overrun;
  flag_vec_t set_vec, clr_vec, flags;

  assign ne_eff   = char_ne & ~cfg_one_sample;
  assign char_err = char_fe | char_pe | ne_eff;

  rx_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk, .rst_n, .char_stb, .char_data, .char_err, .rd_stb,
    .cfg_ovr_off, .cfg_err_dma_mask,
    .rx_data, .rx_valid, .accept, .overrun
  );

  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_FE]  = accept & char_fe;
    set_vec[FLAG_NE]  = accept & ne_eff;
    set_vec[FLAG_PE]  = accept & char_pe;
    set_vec[FLAG_ORE] = overrun;
    clr_vec           = '0;
    clr_vec[FLAG_FE]  = clr_fe;
    clr_vec[FLAG_NE]  = clr_ne;
    clr_vec[FLAG_PE]  = clr_pe;
    clr_vec[FLAG_ORE] = clr_ore;
  end

  rx_err_flags u_flags (.clk, .rst_n, .set_vec, .clr_vec, .flags);

  rx_req_irq u_req (
    .clk, .rst_n, .flags, .rx_valid, .cfg_dma_en, .cfg_err_dma_mask,
    .cfg_err_ie, .dma_req, .err_irq
  );

  assign flag_fe  = flags[FLAG_FE];
  assign flag_ne  = flags[FLAG_NE];
  assign flag_pe  = flags[FLAG_PE];
  assign flag_ore = flags[FLAG_ORE];

  // R8: noise never reported in single-sample mode
  a_r8_no_noise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ne) |-> !$past(cfg_one_sample));
  // R5: overrun flag only rises with detection on
  a_r5_no_ore: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ore) |-> $past(!cfg_ovr_off && char_stb));
endmodule

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;
  localparam int unsigned DW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_stb = 0, char_fe = 0, char_ne = 0, char_pe = 0, rd_stb = 0;
  logic [DW-1:0] char_data = '0;
  logic clr_fe = 0, clr_ne = 0, clr_pe = 0, clr_ore = 0;
  logic cfg_ovr_off = 0, cfg_err_dma_mask = 0, cfg_dma_en = 0, cfg_err_ie = 0, cfg_one_sample = 0;
  logic [DW-1:0] rx_data;
  logic rx_valid, flag_fe, flag_ne, flag_pe, flag_ore, dma_req, err_irq;

  int unsigned total = 0, bad = 0;
  logic done = 1'b0;

  // reference state
  logic [DW-1:0] m_data = '0;
  logic m_valid = 0, m_fe = 0, m_ne = 0, m_pe = 0, m_ore = 0;

  always #4 clk = ~clk;

  uart_rx_status #(.DATA_W(DW)) u_uart_rx_status (.*);

  function automatic logic exp_dma();
    return cfg_dma_en & m_valid & ~(cfg_err_dma_mask & (m_fe | m_ne | m_pe));
  endfunction

  function automatic logic exp_irq();
    return cfg_err_ie & (m_fe | m_ore | m_ne);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic ovr, acc, ne_e, err;
    ovr  = char_stb & m_valid & ~rd_stb & ~cfg_ovr_off;
    acc  = char_stb & ~ovr;
    ne_e = char_ne & ~cfg_one_sample;
    err  = char_fe | char_pe | ne_e;
    if (acc) begin
      m_data  = char_data;
      m_valid = ~err | cfg_err_dma_mask;
    end else if (rd_stb) m_valid = 1'b0;
    m_fe  = (acc & char_fe) | (m_fe  & ~clr_fe);
    m_ne  = (acc & ne_e)    | (m_ne  & ~clr_ne);
    m_pe  = (acc & char_pe) | (m_pe  & ~clr_pe);
    m_ore = ovr             | (m_ore & ~clr_ore);
  endtask

  task automatic chk_all();
    chk("R2 data", 32'(rx_data), 32'(m_data));
    chk("R3 valid", 32'(rx_valid), 32'(m_valid));
    chk("R9 fe", 32'(flag_fe), 32'(m_fe));
    chk("R8 ne", 32'(flag_ne), 32'(m_ne));
    chk("R9 pe", 32'(flag_pe), 32'(m_pe));
    chk("R4 ore", 32'(flag_ore), 32'(m_ore));
    chk("R10 dma", 32'(dma_req), 32'(exp_dma()));
    chk("R11 irq", 32'(err_irq), 32'(exp_irq()));
  endtask

  task automatic quiet();
    char_stb = 0; char_fe = 0; char_ne = 0; char_pe = 0; rd_stb = 0;
    clr_fe = 0; clr_ne = 0; clr_pe = 0; clr_ore = 0;
  endtask

  // inputs set at a negedge; one clock later the outputs are compared
  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk_all();
    quiet();
  endtask

  task automatic send(input logic [DW-1:0] d, input logic fe, input logic ne, input logic pe);
    char_stb = 1; char_data = d; char_fe = fe; char_ne = ne; char_pe = pe;
    tick();
  endtask

  task automatic clear_all();
    rd_stb = 1; clr_fe = 1; clr_ne = 1; clr_pe = 1; clr_ore = 1;
    tick();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: values held during reset
    chk("R1 data in reset", 32'(rx_data), 0);
    chk("R1 flags in reset", 32'({rx_valid, flag_fe, flag_ne, flag_pe, flag_ore, dma_req, err_irq}), 0);
    rst_n = 1'b1;
    cfg_dma_en = 1; cfg_err_ie = 1;
    @(negedge clk);
    chk("R1 after reset", 32'({rx_valid, flag_fe, flag_ne, flag_pe, flag_ore, dma_req, err_irq}), 0);
    chk_all();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 80 == 0) begin
        cfg_ovr_off      = ($urandom % 3) == 0;
        cfg_err_dma_mask = $urandom % 2;
        cfg_dma_en       = ($urandom % 4) != 0;
        cfg_err_ie       = ($urandom % 4) != 0;
        cfg_one_sample   = ($urandom % 3) == 0;
      end
      char_stb  = ($urandom % 3) == 0;
      char_data = DW'($urandom);
      char_fe   = ($urandom % 5) == 0;
      char_ne   = ($urandom % 5) == 0;
      char_pe   = ($urandom % 5) == 0;
      rd_stb    = ($urandom % 3) == 0;
      clr_fe    = ($urandom % 6) == 0;
      clr_ne    = ($urandom % 6) == 0;
      clr_pe    = ($urandom % 6) == 0;
      clr_ore   = ($urandom % 6) == 0;
      tick();
    end

    // directed: overrun detection on (R4) and read-with-arrival (R3)
    cfg_ovr_off = 0; cfg_err_dma_mask = 0; cfg_one_sample = 0; cfg_dma_en = 1; cfg_err_ie = 1;
    clear_all();
    send(9'h0A5, 0, 0, 0);
    chk("R2 first char", 32'(rx_data), 32'h0A5);
    send(9'h15A, 0, 0, 0);
    chk("R4 old data kept", 32'(rx_data), 32'h0A5);
    chk("R4 ore set", 32'(flag_ore), 1);
    chk("R11 irq on ore", 32'(err_irq), 1);
    rd_stb = 1; char_stb = 1; char_data = 9'h033; tick();
    chk("R3 read+char accepted", 32'(rx_data), 32'h033);
    chk("R3 valid after read+char", 32'(rx_valid), 1);

    // directed: overrun off (R5)
    clear_all();
    cfg_ovr_off = 1;
    send(9'h011, 0, 0, 0);
    send(9'h122, 0, 0, 0);
    chk("R5 overwrite", 32'(rx_data), 32'h122);
    chk("R5 no ore", 32'(flag_ore), 0);

    // directed: error with valid suppressed (R6)
    clear_all();
    cfg_ovr_off = 0;
    send(9'h044, 1, 0, 0);
    chk("R6 fe set", 32'(flag_fe), 1);
    chk("R6 valid low", 32'(rx_valid), 0);
    chk("R10 no dma", 32'(dma_req), 0);
    send(9'h055, 0, 0, 0);
    chk("R6 next good valid", 32'(rx_valid), 1);
    chk("R10 dma on good", 32'(dma_req), 1);

    // directed: error with DMA masking (R7)
    clear_all();
    cfg_err_dma_mask = 1;
    send(9'h066, 0, 0, 1);
    chk("R7 valid set", 32'(rx_valid), 1);
    chk("R7 dma masked", 32'(dma_req), 0);
    chk("R11 pe alone no irq", 32'(err_irq), 0);
    clr_pe = 1; tick();
    chk("R7 dma after clear", 32'(dma_req), 1);

    // directed: single-sample ignores noise (R8)
    clear_all();
    cfg_one_sample = 1; cfg_err_dma_mask = 0;
    send(9'h077, 0, 1, 0);
    chk("R8 ne ignored", 32'(flag_ne), 0);
    chk("R8 char good", 32'(rx_valid), 1);

    // directed: set beats clear (R9)
    clear_all();
    send(9'h088, 1, 0, 0);
    char_stb = 1; char_data = 9'h099; char_fe = 1; clr_fe = 1; tick();
    chk("R9 set wins", 32'(flag_fe), 1);
    clr_fe = 1; tick();
    chk("R9 cleared", 32'(flag_fe), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule